// File: doc/BRIEF.md
# Serial BCD Digit Validity Checker

This block watches a one-bit serial stream and cuts it into back-to-back groups of four bits, with the least significant bit of each group first. On the cycle that carries the fourth and most significant bit, it decides whether the group is a decimal digit (0 to 9) or an illegal code (10 to 15). For an illegal code it raises a one-bit flag in that same cycle.

The check runs as the bits arrive, so no nibble is ever stored. A code is illegal exactly when its top bit is set together with bit 1 or bit 2. For that reason the machine only remembers where it is in the group and whether bit 1 or bit 2 has been seen high. The result is six states held in three flip-flops.

A qualifier input lets the source pause the stream. While it is low, the machine keeps its position and the flag stays quiet. A synchronous active-low reset returns the machine to the start of a group.

Top module: `bcd_serial_guard`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the machine returns to the start of a group. The first qualified bit after reset is taken as bit 0 (the LSB) of a new group, and `bad_digit` is 0 for as long as `rst_n` is low.
- R2: A bit is consumed only on a rising edge where `bit_vld` is 1. While `bit_vld` is 0, the position in the group and the recorded bits are held, and `bad_digit` is 0 whatever `bit_in` is.
- R3: On the first, second and third qualified bits of every group, `bad_digit` is 0 for any data.
- R4: On the fourth qualified bit, `bad_digit` is 1 in that same cycle, combinationally from `bit_in`, exactly when the group value b0 + 2*b1 + 4*b2 + 8*b3 is greater than 9. Here b0 is the first bit received and b3 is the fourth.
- R5: After four qualified bits the machine is back at the start of a group. Groups follow each other with no gap, and the framing period is always exactly four qualified bits.
- R6: Pausing with `bit_vld` low at any position in a group, including just before the fourth bit, does not change the verdict for that group or the framing of the groups that follow.
- R7: The state register is three bits wide and only ever holds one of six legal codes: 0 = start, 1 = one bit seen, 2 = two bits seen with bit 1 low, 3 = two bits seen with bit 1 high, 4 = three bits seen with bits 1 and 2 low, 5 = three bits seen with bit 1 or bit 2 high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_vld | input | 1 | High when `bit_in` carries a stream bit this cycle |
| bit_in | input | 1 | Serial data, LSB of each group first |
| bad_digit | output | 1 | High on the fourth bit of a group whose value exceeds 9 |

## Verification
The bench sends all sixteen codes in a shuffled order and checks both sides of the decision boundary, 9 against 10. A machine that tested the wrong bit pair, or that read the bits MSB-first, would misjudge codes such as 9, 10 and 12.

Codes like 15 and 14 have high bits early in the group. A design that let the flag leak onto a non-final position would pulse before the fourth bit on these codes.

Two further cases target the qualifier. A pause exactly at the fourth slot, with `bit_in` held high, catches a flag that ignores `bit_vld`. Pauses in the middle of a group catch a machine that advances anyway, because every later group would then be misframed.

A reset after two bits of a group checks that the count restarts. Runs of back-to-back groups would expose a machine that drifts by one position after an illegal code.

// File: rtl/bcd_guard_pkg.sv
// Package: shared state type and encoding for the serial BCD checker.
// Assumes groups of four bits, LSB first; the encoding is binary and dense
// so the six states fit in three flip-flops.
package bcd_guard_pkg;

    localparam int GROUP_BITS = 4;
    localparam int STATE_W    = 3;
    localparam int NUM_STATES = 6;
    localparam int MAX_DIGIT  = 9;

    // Position in the group plus "bit 1 or bit 2 seen high" where it matters.
    typedef enum logic [STATE_W-1:0] {
        ST_START     = 3'd0,
        ST_ONE       = 3'd1,
        ST_TWO_CLR   = 3'd2,
        ST_TWO_SET   = 3'd3,
        ST_THREE_CLR = 3'd4,
        ST_THREE_SET = 3'd5
    } guard_state_t;

endpackage

// File: rtl/bcd_guard_next.sv
// Module: next-state logic of the checker.
// Walks one step per qualified bit. It remembers only whether bit 1 or
// bit 2 of the group was high, and it wraps to ST_START after the fourth
// bit. It holds the state while the qualifier is low.
// Assumes: illegal codes never arise, but recover to ST_START if seen.
module bcd_guard_next
    import bcd_guard_pkg::*;
(
    input  guard_state_t cur,
    input  logic         bit_vld,
    input  logic         bit_in,
    output guard_state_t nxt
);

    // Purpose: select the successor state for the current bit.
    always_comb begin
        nxt = cur;
        if (bit_vld) begin
            unique case (cur)
                ST_START:     nxt = ST_ONE;
                ST_ONE:       nxt = bit_in ? ST_TWO_SET : ST_TWO_CLR;
                ST_TWO_CLR:   nxt = bit_in ? ST_THREE_SET : ST_THREE_CLR;
                ST_TWO_SET:   nxt = ST_THREE_SET;
                ST_THREE_CLR: nxt = ST_START;
                ST_THREE_SET: nxt = ST_START;
                default:      nxt = ST_START;
            endcase
        end
    end

endmodule

// File: rtl/bcd_guard_reg.sv
// Module: state register of the checker.
// Holds the three-bit state. A synchronous active-low reset forces ST_START.
// Assumes: rst_n is synchronous to clk.
module bcd_guard_reg
    import bcd_guard_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  guard_state_t d,
    output guard_state_t q
);

    // Purpose: capture the next state, or restart the group on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= ST_START;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/bcd_guard_flag.sv
// Module: Mealy output decode of the checker.
// Flags an illegal code on the fourth bit. Bit 3 is high and the state
// records that bit 1 or bit 2 was high. Stays quiet when the bit is not
// qualified or the block is in reset.
// Assumes: the flag is consumed in the same cycle (no register on the path).
module bcd_guard_flag
    import bcd_guard_pkg::*;
(
    input  guard_state_t cur,
    input  logic         rst_n,
    input  logic         bit_vld,
    input  logic         bit_in,
    output logic         bad_digit
);

    // Purpose: raise the flag only on a qualified top bit of a marked group.
    always_comb begin
        bad_digit = rst_n && bit_vld && bit_in && (cur == ST_THREE_SET);
    end

endmodule

// File: rtl/bcd_serial_guard.sv
// Module: top of the serial BCD digit validity checker.
// Frames a serial stream into 4-bit groups, LSB first, and flags any group
// above 9 in the cycle that carries its fourth bit.
// Assumes: groups are back to back from reset; bit_vld qualifies each bit.
module bcd_serial_guard
    import bcd_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic bit_in,
    output logic bad_digit
);

    guard_state_t cur_state;
    guard_state_t nxt_state;

    bcd_guard_next u_next (
        .cur     (cur_state),
        .bit_vld (bit_vld),
        .bit_in  (bit_in),
        .nxt     (nxt_state)
    );

    bcd_guard_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nxt_state),
        .q     (cur_state)
    );

    bcd_guard_flag u_flag (
        .cur       (cur_state),
        .rst_n     (rst_n),
        .bit_vld   (bit_vld),
        .bit_in    (bit_in),
        .bad_digit (bad_digit)
    );

endmodule

// File: rtl/bcd_guard_chk.sv
// Module: assertion checker for bcd_serial_guard, bound to the top.
// Keeps its own count of qualified bits and a shift record of the
// first three bits, and checks the ports and state against them.
// Assumes: rst_n is held low for the first clock edge of the run.
module bcd_guard_chk
    import bcd_guard_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         bit_vld,
    input logic         bit_in,
    input logic         bad_digit,
    input guard_state_t state
);

    logic [1:0] pos_cnt;
    logic [2:0] low_bits;
    logic [STATE_W-1:0] state_bits;

    assign state_bits = state;

    // Purpose: track the bit position and the bits seen so far in the group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_cnt  <= 2'd0;
            low_bits <= 3'd0;
        end else if (bit_vld) begin
            pos_cnt  <= pos_cnt + 2'd1;
            low_bits <= {bit_in, low_bits[2:1]};
        end
    end

    // R3
    no_early_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_cnt != 2'd3) |-> !bad_digit);

    // R4
    flag_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && pos_cnt == 2'd3) |-> (bad_digit == ({bit_in, low_bits} > 4'd9)));

    // R2
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |-> !bad_digit);

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> (state == $past(state)));

    // R5
    frame_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && pos_cnt == 2'd3) |=> (state == ST_START));

    // R7
    legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_bits < 3'(NUM_STATES));

endmodule

bind bcd_serial_guard bcd_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_vld   (bit_vld),
    .bit_in    (bit_in),
    .bad_digit (bad_digit),
    .state     (cur_state)
);

// File: tb/bcd_serial_guard_test.sv
module bcd_serial_guard_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_vld = 1'b0;
    logic bit_in = 1'b0;
    logic bad_digit;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    bcd_serial_guard uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_vld   (bit_vld),
        .bit_in    (bit_in),
        .bad_digit (bad_digit)
    );

    task automatic check(input logic got, input logic exp, input string tag);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: bad_digit=%b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // One qualified bit; the flag is sampled 2 ns after driving, before the edge.
    task automatic send_bit(input logic b, input logic exp, input string tag);
        @(negedge clk);
        rst_n = 1'b1; bit_vld = 1'b1; bit_in = b;
        #2 check(bad_digit, exp, tag);
    endtask

    task automatic idle(input int n, input logic b, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_vld = 1'b0; bit_in = b;
            #2 check(bad_digit, 1'b0, tag);
        end
    endtask

    // Four bits LSB first; flag expected only on the last when value > 9.
    task automatic send_nibble(input logic [3:0] v, input string tag);
        for (int i = 0; i < 4; i++)
            send_bit(v[i], (i == 3) && (v > 4'd9), (i == 3) ? tag : "R3");
    endtask

    task automatic t_reset();
        // R1: flag quiet while reset is held, even with a qualified 1
        rst_n = 1'b0; bit_vld = 1'b1; bit_in = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            #2 check(bad_digit, 1'b0, "R1");
        end
        @(negedge clk);
        rst_n = 1'b1; bit_vld = 1'b0;
    endtask

    task automatic t_all_codes();
        // R4 R7: every code once, shuffled by an odd stride
        for (int k = 0; k < 16; k++)
            send_nibble(4'((k * 7 + 5) % 16), "R4");
    endtask

    task automatic t_back_to_back();
        // R5: groups with no gap around the 9/10 boundary
        send_nibble(4'd10, "R5");
        send_nibble(4'd9,  "R5");
        send_nibble(4'd15, "R5");
        send_nibble(4'd0,  "R5");
        send_nibble(4'd11, "R5");
        send_nibble(4'd8,  "R5");
    endtask

    task automatic t_stall();
        // R6: 12 = bits 0,0,1,1 with pauses at every slot
        send_bit(1'b0, 1'b0, "R6");
        idle(2, 1'b1, "R2");
        send_bit(1'b0, 1'b0, "R6");
        idle(1, 1'b1, "R2");
        send_bit(1'b1, 1'b0, "R6");
        idle(3, 1'b1, "R2");
        send_bit(1'b1, 1'b1, "R6");
        send_nibble(4'd13, "R6");
        idle(1, 1'b0, "R2");
        send_nibble(4'd3, "R6");
    endtask

    task automatic t_mid_reset();
        // R1: reset after two bits restarts the group count
        send_bit(1'b1, 1'b0, "R3");
        send_bit(1'b1, 1'b0, "R3");
        @(negedge clk);
        rst_n = 1'b0; bit_vld = 1'b1; bit_in = 1'b1;
        #2 check(bad_digit, 1'b0, "R1");
        @(negedge clk);
        rst_n = 1'b1; bit_vld = 1'b0;
        send_nibble(4'd12, "R1");
        send_nibble(4'd6,  "R1");
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_all_codes();
        t_back_to_back();
        t_stall();
        t_mid_reset();
        idle(2, 1'b0, "R2");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule